// File: doc/BRIEF.md
# Moderated Event Interrupter

This block is a single interrupter for a host controller's event path. It holds three software-visible dword registers: a management register with a pending flag and an enable flag, a moderation register that pairs a minimum interval with a hardware countdown, and a dequeue register carrying a handler-busy flag and a segment index hint. An upstream event writer tells it when an event has just been posted and whether the event ring still holds unserviced entries. A free-running strobe, one cycle every 250 ns, drives the countdown.

The interrupt line is throttled. The countdown drops by one per strobe and stops at zero. An interrupt is raised only when the countdown is zero, nothing is already pending, interrupts are enabled, the handler is not busy and events are waiting. Raising it sets pending and busy and reloads the countdown from the interval. If the ring is empty when the countdown expires, the interrupt waits for the next event, so the spacing between interrupts can exceed the interval. Software clears pending and busy by writing ones. The asynchronous reset is released through a two-stage synchronizer before it reaches the registers.

Top module: `evt_interrupter`

## Requirements
- R1: After reset the management register reads 0, the dequeue register reads 0, the moderation register reads INTERVAL_RESET in bits 15:0 with a countdown of 0 in bits 31:16, and irq is low.
- R2: At register address 0, bit 0 is pending and bit 1 is enable. Enable takes the written value. Writing 1 to bit 0 clears pending and writing 0 leaves it unchanged. Software cannot set pending. Bits 31:2 hold whatever was last written to them.
- R3: At register address 1, bits 15:0 are the interval and bits 31:16 are the countdown. A write loads both fields from the written data.
- R4: Each cycle with tick high lowers a nonzero countdown by one. A countdown of 0 stays at 0.
- R5: When the countdown is 0, pending is 0, enable is 1, busy is 0 and either ring_nonempty or event_posted is high at a clock edge, then after that edge pending and busy are 1, the countdown equals the interval and irq is high.
- R6: No interrupt is raised while enable is 0, busy is 1, the countdown is nonzero, or both ring_nonempty and event_posted are low.
- R7: irq is high exactly when pending and enable are both 1. Clearing enable drops irq and leaves pending set.
- R8: At register address 2, bit 3 is busy and bits 2:0 are the segment hint. Writing 1 to bit 3 clears busy and writing 0 leaves it unchanged. Bits 2:0 and bits 31:4 take the written value.
- R9: A moderation write in the same cycle as an interrupt reload wins, and the countdown takes the written value.
- R10: Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle strobe every 250 ns |
| event_posted | input | 1 | An event was written to the ring this cycle |
| ring_nonempty | input | 1 | The event ring holds unserviced events |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Dword register select: 0 management, 1 moderation, 2 dequeue |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with INTERVAL_RESET set to 5 and leaves the countdown 16 bits wide. The short reset interval lets the reset readback be checked quickly. The bench writes countdowns of 2 to 9 directly, so every expiry, saturation at zero and reload is reached within a few strobes. This keeps each gating condition (enable, busy, empty ring, nonzero countdown), the write-versus-reload collision and the event_posted path within a short run.

// File: rtl/evt_intr_pkg.sv
package evt_intr_pkg;
  localparam int DW     = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MGMT = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_DEQ  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int MGMT_PEND_BIT = 0;
  localparam int MGMT_EN_BIT   = 1;
endpackage

// File: rtl/evt_mgmt_reg.sv
module evt_mgmt_reg
  import evt_intr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          set_pend,
  output logic          pend,
  output logic          en,
  output logic [DW-3:0] spare
);
  logic          pend_d, en_d, ce;
  logic [DW-3:0] spare_d;

  always_comb begin
    ce      = wr_en | set_pend;
    pend_d  = pend;
    en_d    = en;
    spare_d = spare;
    if (wr_en) begin
      en_d    = wdata[MGMT_EN_BIT];
      spare_d = wdata[DW-1:2];
      if (wdata[MGMT_PEND_BIT]) pend_d = 1'b0;
    end
    if (set_pend) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      en    <= 1'b0;
      spare <= '0;
    end else if (ce) begin
      pend  <= pend_d;
      en    <= en_d;
      spare <= spare_d;
    end
  end

  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wr_en && wdata[MGMT_PEND_BIT]) |=> !pend); // R2
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en == $past(wdata[MGMT_EN_BIT]))); // R2
endmodule

// File: rtl/evt_mod_timer.sv
module evt_mod_timer
  import evt_intr_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int INTERVAL_RESET = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic             tick,
  input  logic             reload,
  output logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic             zero
);
  localparam logic [CNT_W-1:0] IVL_INIT = CNT_W'(INTERVAL_RESET);

  logic [CNT_W-1:0] interval_d, count_d;
  logic             ce;

  assign zero = (count == '0);

  always_comb begin
    ce         = wr_en | reload | (tick & ~zero);
    interval_d = interval;
    count_d    = count;
    if (wr_en) begin
      interval_d = wdata[CNT_W-1:0];
      count_d    = wdata[2*CNT_W-1:CNT_W];
    end else if (reload) begin
      count_d    = interval;
    end else if (tick && !zero) begin
      count_d    = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval <= IVL_INIT;
      count    <= '0;
    end else if (ce) begin
      interval <= interval_d;
      count    <= count_d;
    end
  end

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && !reload && count != '0) |=> (count == CNT_W'($past(count) - 1'b1))); // R4
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && !reload && count == '0) |=> (count == '0)); // R4
  AST_RELOAD_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_en) |=> (count == $past(interval))); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wdata[2*CNT_W-1:CNT_W]))); // R9
endmodule

// File: rtl/evt_deq_reg.sv
module evt_deq_reg
  import evt_intr_pkg::*;
#(
  parameter int SEG_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DW-1:0]       wdata,
  input  logic                set_busy,
  output logic                busy,
  output logic [SEG_W-1:0]    seg,
  output logic [DW-SEG_W-2:0] hi
);
  localparam int BUSY_BIT = SEG_W;

  logic                busy_d, ce;
  logic [SEG_W-1:0]    seg_d;
  logic [DW-SEG_W-2:0] hi_d;

  always_comb begin
    ce     = wr_en | set_busy;
    busy_d = busy;
    seg_d  = seg;
    hi_d   = hi;
    if (wr_en) begin
      seg_d = wdata[SEG_W-1:0];
      hi_d  = wdata[DW-1:BUSY_BIT+1];
      if (wdata[BUSY_BIT]) busy_d = 1'b0;
    end
    if (set_busy) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      seg  <= '0;
      hi   <= '0;
    end else if (ce) begin
      busy <= busy_d;
      seg  <= seg_d;
      hi   <= hi_d;
    end
  end

  AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_en && wdata[BUSY_BIT])) |=> busy); // R8
  AST_SEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (seg == $past(wdata[SEG_W-1:0]))); // R8
endmodule

// File: rtl/evt_interrupter.sv
module evt_interrupter
  import evt_intr_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int INTERVAL_RESET = 4000,
  parameter int SEG_W          = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              event_posted,
  input  logic              ring_nonempty,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_in_n = rst_pipe[1];

  reg_sel_e sel;
  logic     wr_mgmt, wr_mod, wr_deq;
  assign sel     = reg_sel_e'(reg_addr);
  assign wr_mgmt = reg_wr && (sel == SEL_MGMT);
  assign wr_mod  = reg_wr && (sel == SEL_MOD);
  assign wr_deq  = reg_wr && (sel == SEL_DEQ);

  logic                pend, en, busy, cnt_zero, fire, events_waiting;
  logic [DW-3:0]       mgmt_spare;
  logic [CNT_W-1:0]    interval, count;
  logic [SEG_W-1:0]    seg;
  logic [DW-SEG_W-2:0] deq_hi;

  assign events_waiting = ring_nonempty | event_posted;
  assign fire = cnt_zero & ~pend & en & ~busy & events_waiting;

  evt_mgmt_reg u_mgmt (
    .clk(clk), .rst_n(rst_in_n), .wr_en(wr_mgmt), .wdata(reg_wdata),
    .set_pend(fire), .pend(pend), .en(en), .spare(mgmt_spare)
  );

  evt_mod_timer #(.CNT_W(CNT_W), .INTERVAL_RESET(INTERVAL_RESET)) u_timer (
    .clk(clk), .rst_n(rst_in_n), .wr_en(wr_mod), .wdata(reg_wdata),
    .tick(tick), .reload(fire), .interval(interval), .count(count),
    .zero(cnt_zero)
  );

  evt_deq_reg #(.SEG_W(SEG_W)) u_deq (
    .clk(clk), .rst_n(rst_in_n), .wr_en(wr_deq), .wdata(reg_wdata),
    .set_busy(fire), .busy(busy), .seg(seg), .hi(deq_hi)
  );

  assign irq = pend & en;

  always_comb begin
    unique case (sel)
      SEL_MGMT: reg_rdata = {mgmt_spare, en, pend};
      SEL_MOD:  reg_rdata = DW'({count, interval});
      SEL_DEQ:  reg_rdata = {deq_hi, busy, seg};
      default:  reg_rdata = '0;
    endcase
  end

  AST_FIRE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_in_n)
    fire |=> (pend && busy && irq)); // R5
  AST_PEND_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_in_n)
    $rose(pend) |-> $past(en && !busy && cnt_zero && events_waiting)); // R6
endmodule

// File: tb/evt_interrupter_tb.sv
`timescale 1ns/1ps
module evt_interrupter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, event_posted, ring_nonempty, reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  evt_interrupter #(.CNT_W(16), .INTERVAL_RESET(5), .SEG_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .event_posted(event_posted),
    .ring_nonempty(ring_nonempty), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = exp_q.pop_front();
      got = it.is_irq ? {31'd0, irq} : reg_rdata;
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk); #0.5;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk); #0.5;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic do_tick();
    @(posedge clk); #1;
    tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    rst_n = 1'b0; tick = 0; event_posted = 0; ring_nonempty = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1: reset values
    expect_reg(2'd0, 32'h0000_0000, "R1 mgmt");
    expect_reg(2'd1, 32'h0000_0005, "R1 moderation");
    expect_reg(2'd2, 32'h0000_0000, "R1 dequeue");
    expect_irq(1'b0, "R1 irq");

    // R2: enable and upper bits stored
    wr(2'd0, 32'hFFFF_FFFC);
    expect_reg(2'd0, 32'hFFFF_FFFC, "R2 upper bits kept");
    wr(2'd0, 32'h0000_0000);
    expect_reg(2'd0, 32'h0000_0000, "R2 cleared back");

    // R3 / R4: moderation load, countdown and saturation
    wr(2'd1, 32'h0003_0007);
    expect_reg(2'd1, 32'h0003_0007, "R3 moderation write");
    do_tick();
    expect_reg(2'd1, 32'h0002_0007, "R4 decrement");
    do_tick(); do_tick(); do_tick();
    expect_reg(2'd1, 32'h0000_0007, "R4 saturate at zero");

    // R8: dequeue fields, busy W1C with busy clear
    wr(2'd2, 32'hABCD_E5FF);
    expect_reg(2'd2, 32'hABCD_E5F7, "R8 dequeue fields");
    wr(2'd2, 32'h0000_0000);
    expect_reg(2'd2, 32'h0000_0000, "R8 dequeue cleared");

    // R10: unused address
    wr(2'd3, 32'hFFFF_FFFF);
    expect_reg(2'd3, 32'h0000_0000, "R10 unused reads zero");
    expect_reg(2'd0, 32'h0000_0000, "R10 write had no effect");

    // R6: disabled with events -> no interrupt
    ring_nonempty = 1'b1;
    idle(3);
    expect_reg(2'd0, 32'h0000_0000, "R6 enable low blocks");
    ring_nonempty = 1'b0;
    wr(2'd0, 32'h0000_0002);
    idle(3);
    expect_reg(2'd0, 32'h0000_0002, "R6 empty ring blocks");
    wr(2'd1, 32'h0002_0007);
    ring_nonempty = 1'b1;
    idle(3);
    expect_reg(2'd0, 32'h0000_0002, "R6 nonzero countdown blocks");
    expect_irq(1'b0, "R6 irq low");

    // R5: countdown expires -> interrupt
    do_tick(); do_tick();
    idle(1);
    expect_reg(2'd0, 32'h0000_0003, "R5 pending set");
    expect_reg(2'd2, 32'h0000_0008, "R5 busy set");
    expect_reg(2'd1, 32'h0007_0007, "R5 countdown reloaded");
    expect_irq(1'b1, "R5 irq high");

    // R2: writing 0 to pending leaves it set
    wr(2'd0, 32'h0000_0002);
    expect_reg(2'd0, 32'h0000_0003, "R2 pending not cleared by 0");

    // R7: enable low drops irq, pending remains
    wr(2'd0, 32'h0000_0000);
    expect_reg(2'd0, 32'h0000_0001, "R7 pending kept");
    expect_irq(1'b0, "R7 irq low when disabled");

    // R2: clear pending with enable on
    wr(2'd0, 32'h0000_0003);
    expect_reg(2'd0, 32'h0000_0002, "R2 pending W1C");

    // R6: busy blocks with zero countdown and events
    wr(2'd1, 32'h0000_0007);
    idle(3);
    expect_reg(2'd0, 32'h0000_0002, "R6 busy blocks");
    expect_irq(1'b0, "R6 irq low while busy");

    // R8 / R5: clearing busy lets interrupt fire
    wr(2'd2, 32'h0000_0008);
    idle(1);
    expect_reg(2'd0, 32'h0000_0003, "R5 fires after busy clear");
    expect_reg(2'd2, 32'h0000_0008, "R8 busy set again");
    expect_reg(2'd1, 32'h0007_0007, "R5 second reload");

    // R9: moderation write collides with reload, event_posted source
    ring_nonempty = 1'b0;
    wr(2'd0, 32'h0000_0003);
    wr(2'd2, 32'h0000_0008);
    wr(2'd1, 32'h0000_0007);
    idle(3);
    expect_reg(2'd0, 32'h0000_0002, "R6 empty ring after expiry");
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0009_0004; event_posted = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; event_posted = 1'b0;
    expect_reg(2'd1, 32'h0009_0004, "R9 write beats reload");
    expect_reg(2'd0, 32'h0000_0003, "R5 event_posted fires");
    expect_irq(1'b1, "R5 irq via event_posted");

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule